// File: doc/BRIEF.md
# CPU Word Port to Cipher Block Buffer

This block connects a 32-bit processor data port to a cipher core that consumes and produces 64-bit blocks. On the input side the processor writes words one at a time. The block packs each pair into a 64-bit block and offers it to the core over a valid/ready handshake. On the output side the block takes 64-bit result blocks from the core over a second handshake and hands them back as words, one per processor read.

Each side buffers two blocks (four words). Three static mode inputs shape the data. Input byte reversal turns each written word from byte order 3-2-1-0 into 0-1-2-3. Output byte reversal does the same to each word returned on a read. Half swap exchanges the two 32-bit halves of every block, and it applies to both sides.

Six status flags report the state of the buffers: empty and full for each side, plus a sticky error flag for each side. A write to a full input buffer and a read from an empty output buffer are both errors. The `start` pulse begins a new operation. It empties both buffers and clears both error flags.

Top module: `wp_data_port`

## Requirements
- R1: After reset, `in_empty` and `out_empty` are 1, and `in_full`, `out_full`, `in_err`, `out_err` and `blk_out_valid` are 0.
- R2: With half swap off, the first of two written words becomes bits 63:32 of the block on `blk_out_data`, and the second word becomes bits 31:0.
- R3: `in_empty` is 1 only when the input buffer holds no words. `in_full` is 1 when it holds four words. `blk_out_valid` is 1 when it holds at least two words.
- R4: A write while `in_full` is 1 sets `in_err`, and the written word is discarded.
- R5: A read while `out_empty` is 1 sets `out_err`, and `rd_data` is zero whenever the output buffer is empty.
- R6: With `in_swap` set, each written word is stored with its bytes reversed: bits 7:0 move to 31:24, and so on.
- R7: With `out_swap` set, each word presented on `rd_data` has its bytes reversed.
- R8: With `blk_swap` set, the first written word forms bits 31:0 of the outgoing block. For incoming blocks, bits 31:0 are the first word read out.
- R9: With half swap off, the first read of an accepted block returns bits 63:32. `blk_in_ready` is 0 when fewer than two word slots are free, and `out_full` is 1 when four words are held.
- R10: `in_err` and `out_err` stay set until a `start` pulse. The cycle after `start`, both error flags are clear and both buffers are empty.
- R11: While `blk_out_valid` is 1 and `blk_out_ready` is 0, the offered block and its valid stay unchanged, even if more words are written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation: flushes both buffers and clears error flags |
| in_swap | input | 1 | Reverse bytes of each written word |
| out_swap | input | 1 | Reverse bytes of each read word |
| blk_swap | input | 1 | Exchange the halves of each block, both directions |
| wr_en | input | 1 | Processor word write strobe |
| wr_data | input | 32 | Processor write word |
| rd_en | input | 1 | Processor word read strobe |
| rd_data | output | 32 | Word at the head of the output buffer, zero when empty |
| in_empty | output | 1 | Input buffer holds no words |
| in_full | output | 1 | Input buffer holds four words |
| in_err | output | 1 | Sticky: write attempted while input buffer was full |
| out_empty | output | 1 | Output buffer holds no words |
| out_full | output | 1 | Output buffer holds four words |
| out_err | output | 1 | Sticky: read attempted while output buffer was empty |
| blk_out_valid | output | 1 | A packed block is offered to the core |
| blk_out_ready | input | 1 | Core accepts the offered block |
| blk_out_data | output | 64 | Packed block to the core |
| blk_in_valid | input | 1 | Core offers a result block |
| blk_in_ready | output | 1 | Output buffer can take a block |
| blk_in_data | input | 64 | Result block from the core |

## Verification
The bench sweeps all eight combinations of the three swap modes. In each combination it fills, overfills and drains both buffers and computes every expected word from the written pattern. Four kinds of fault are targeted:

- A packing order reversed on one side only would show up as swapped halves in only some mode combinations.
- A byte reversal applied to the wrong side would corrupt words only when exactly one of the two byte-swap modes is set.
- An overfull write that is not discarded would corrupt the last block drained to the core.
- An error flag that is not sticky would read back as clear after the buffer drains and before `start`.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int WORD_W = 32;
    localparam int BLK_W  = 2 * WORD_W;

    function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W / 8; i++) begin
            r[8*i +: 8] = w[WORD_W - 8*(i+1) +: 8];
        end
        return r;
    endfunction
endpackage

// File: rtl/wp_word_ring.sv
module wp_word_ring #(
    parameter int W        = 32,
    parameter int DEPTH    = 4,
    parameter int PUSH_MAX = 1,
    parameter int POP_MAX  = 2,
    localparam int PW      = $clog2(DEPTH),
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           flush,
    input  logic [1:0]                     push_n,
    input  logic [PUSH_MAX-1:0][W-1:0]     push_w,
    input  logic [1:0]                     pop_n,
    output logic [POP_MAX-1:0][W-1:0]      heads,
    output logic [CW-1:0]                  count
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } ring_t;

    ring_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            for (int i = 0; i < PUSH_MAX; i++) begin
                if (2'(i) < push_n) begin
                    st_d.mem[PW'(st_q.wp + PW'(i))] = push_w[i];
                end
            end
            st_d.wp  = st_q.wp + PW'(push_n);
            st_d.rp  = st_q.rp + PW'(pop_n);
            st_d.cnt = st_q.cnt + CW'(push_n) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < POP_MAX; g++) begin : g_head
        assign heads[g] = st_q.mem[PW'(st_q.rp + PW'(g))];
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/wp_sticky.sv
module wp_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic set,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clear)    flag_d = 1'b0;
        else if (set) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
endmodule

// File: rtl/wp_data_port.sv
module wp_data_port
    import wp_pkg::*;
#(
    parameter int BLK_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              in_swap,
    input  logic              out_swap,
    input  logic              blk_swap,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              in_empty,
    output logic              in_full,
    output logic              in_err,
    output logic              out_empty,
    output logic              out_full,
    output logic              out_err,
    output logic              blk_out_valid,
    input  logic              blk_out_ready,
    output logic [BLK_W-1:0]  blk_out_data,
    input  logic              blk_in_valid,
    output logic              blk_in_ready,
    input  logic [BLK_W-1:0]  blk_in_data
);
    localparam int WORDS = 2 * BLK_DEPTH;
    localparam int CW    = $clog2(WORDS + 1);

    typedef struct packed {
        logic [1:0]        in_push;
        logic [1:0]        in_pop;
        logic [1:0]        out_push;
        logic [1:0]        out_pop;
        logic              in_err_set;
        logic              out_err_set;
        logic [WORD_W-1:0] in_word;
        logic [WORD_W-1:0] out_first;
        logic [WORD_W-1:0] out_second;
    } ctl_t;

    ctl_t ctl;

    logic [0:0][WORD_W-1:0] in_push_w;
    logic [1:0][WORD_W-1:0] in_heads;
    logic [1:0][WORD_W-1:0] out_push_w;
    logic [0:0][WORD_W-1:0] out_heads;
    logic [CW-1:0]          in_cnt;
    logic [CW-1:0]          out_cnt;

    always_comb begin
        ctl = '0;
        in_empty      = (in_cnt == '0);
        in_full       = (in_cnt == CW'(WORDS));
        out_empty     = (out_cnt == '0);
        out_full      = (out_cnt == CW'(WORDS));
        blk_out_valid = (in_cnt >= CW'(2));
        blk_in_ready  = (out_cnt <= CW'(WORDS - 2)) && !start;

        ctl.in_word = in_swap ? byte_rev(wr_data) : wr_data;
        if (!start) begin
            if (wr_en && !in_full)                     ctl.in_push = 2'd1;
            if (blk_out_valid && blk_out_ready)        ctl.in_pop  = 2'd2;
            if (blk_in_valid && blk_in_ready)          ctl.out_push = 2'd2;
            if (rd_en && !out_empty)                   ctl.out_pop = 2'd1;
            ctl.in_err_set  = wr_en && in_full;
            ctl.out_err_set = rd_en && out_empty;
        end

        ctl.out_first  = blk_swap ? blk_in_data[WORD_W-1:0] : blk_in_data[BLK_W-1:WORD_W];
        ctl.out_second = blk_swap ? blk_in_data[BLK_W-1:WORD_W] : blk_in_data[WORD_W-1:0];

        blk_out_data = blk_swap ? {in_heads[1], in_heads[0]} : {in_heads[0], in_heads[1]};
        if (out_empty)     rd_data = '0;
        else if (out_swap) rd_data = byte_rev(out_heads[0]);
        else               rd_data = out_heads[0];
    end

    assign in_push_w[0]  = ctl.in_word;
    assign out_push_w[0] = ctl.out_first;
    assign out_push_w[1] = ctl.out_second;

    wp_word_ring #(.W(WORD_W), .DEPTH(WORDS), .PUSH_MAX(1), .POP_MAX(2)) u_in_ring (
        .clk(clk), .rst_n(rst_n), .flush(start),
        .push_n(ctl.in_push), .push_w(in_push_w),
        .pop_n(ctl.in_pop), .heads(in_heads), .count(in_cnt)
    );

    wp_word_ring #(.W(WORD_W), .DEPTH(WORDS), .PUSH_MAX(2), .POP_MAX(1)) u_out_ring (
        .clk(clk), .rst_n(rst_n), .flush(start),
        .push_n(ctl.out_push), .push_w(out_push_w),
        .pop_n(ctl.out_pop), .heads(out_heads), .count(out_cnt)
    );

    wp_sticky u_in_err (
        .clk(clk), .rst_n(rst_n), .clear(start), .set(ctl.in_err_set), .flag(in_err)
    );

    wp_sticky u_out_err (
        .clk(clk), .rst_n(rst_n), .clear(start), .set(ctl.out_err_set), .flag(out_err)
    );
endmodule

// File: rtl/wp_port_chk.sv
module wp_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        blk_swap,
    input logic        wr_en,
    input logic        rd_en,
    input logic        in_empty,
    input logic        in_full,
    input logic        in_err,
    input logic        out_empty,
    input logic        out_full,
    input logic        out_err,
    input logic        blk_out_valid,
    input logic        blk_out_ready,
    input logic [63:0] blk_out_data,
    input logic        blk_in_ready
);
    // R4
    in_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_full && !start) |=> in_err);

    // R5
    out_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && out_empty && !start) |=> out_err);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_err || out_err) && !start) |=> (in_err || out_err));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!in_err && !out_err && in_empty && out_empty));

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_out_valid && !blk_out_ready && !start) |=>
            (blk_out_valid && (!$stable(blk_swap) || $stable(blk_out_data))));

    // R3
    in_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_full && in_empty) && (!in_full || blk_out_valid));

    // R9
    out_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> !blk_in_ready);
endmodule

bind wp_data_port wp_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_swap(blk_swap),
    .wr_en(wr_en), .rd_en(rd_en),
    .in_empty(in_empty), .in_full(in_full), .in_err(in_err),
    .out_empty(out_empty), .out_full(out_full), .out_err(out_err),
    .blk_out_valid(blk_out_valid), .blk_out_ready(blk_out_ready),
    .blk_out_data(blk_out_data), .blk_in_ready(blk_in_ready)
);

// File: tb/wp_data_port_bench.sv
module wp_data_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, in_swap = 1'b0, out_swap = 1'b0, blk_swap = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        in_empty, in_full, in_err, out_empty, out_full, out_err;
    logic        blk_out_valid, blk_out_ready = 1'b0, blk_in_valid = 1'b0, blk_in_ready;
    logic [63:0] blk_out_data, blk_in_data = '0;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_data_port u_wp_data_port (.*);

    function automatic logic [31:0] rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic [31:0] w);
        wr_en = 1'b1; wr_data = w;
        step();
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] w [5];
        logic [31:0] s [5];
        logic [63:0] d [2];
        logic [31:0] f;
        #(CLK_PERIOD*2 + 1);
        // R1: reset state
        chk("R1", {in_empty, out_empty, in_full, out_full, in_err, out_err, blk_out_valid},
            7'b1100000);
        rst_n = 1'b1;
        step();
        for (int c = 0; c < 8; c++) begin
            in_swap = c[0]; out_swap = c[1]; blk_swap = c[2];
            start = 1'b1; step(); start = 1'b0;
            chk("R10", {in_empty, out_empty, in_err, out_err}, 4'b1100);
            for (int k = 0; k < 5; k++) begin
                w[k] = 32'h1122_3344 + c * 32'h0101_0101 + k * 32'h1020_3047;
                s[k] = c[0] ? rev(w[k]) : w[k];
            end
            put(w[0]);
            // R3: one word held
            chk("R3", {in_empty, blk_out_valid}, 2'b00);
            put(w[1]);
            chk("R3", blk_out_valid, 1'b1);
            // R2 / R6 / R8: block composition
            chk(c[2] ? "R8" : (c[0] ? "R6" : "R2"), blk_out_data,
                c[2] ? {s[1], s[0]} : {s[0], s[1]});
            put(w[2]);
            put(w[3]);
            chk("R3", in_full, 1'b1);
            put(w[4]);
            // R4: overfull write flagged
            chk("R4", in_err, 1'b1);
            // R11: stalled block holds
            chk("R11", {blk_out_valid, blk_out_data}, {1'b1, c[2] ? {s[1], s[0]} : {s[0], s[1]}});
            blk_out_ready = 1'b1; step();
            // R4: fifth word dropped, second block holds words 2 and 3
            chk("R4", {blk_out_valid, blk_out_data}, {1'b1, c[2] ? {s[3], s[2]} : {s[2], s[3]}});
            step(); blk_out_ready = 1'b0;
            chk("R3", {in_empty, blk_out_valid}, 2'b10);
            // R10: error persists without start
            chk("R10", in_err, 1'b1);
            d[0] = {w[0], w[1]};
            d[1] = {w[2], w[3]};
            for (int b = 0; b < 2; b++) begin
                chk("R9", blk_in_ready, 1'b1);
                blk_in_valid = 1'b1; blk_in_data = d[b]; step(); blk_in_valid = 1'b0;
            end
            chk("R9", {out_full, blk_in_ready}, 2'b10);
            for (int b = 0; b < 2; b++) begin
                for (int h = 0; h < 2; h++) begin
                    f = ((h == 0) != c[2]) ? d[b][63:32] : d[b][31:0];
                    chk(c[1] ? "R7" : "R9", rd_data, c[1] ? rev(f) : f);
                    rd_en = 1'b1; step(); rd_en = 1'b0;
                end
            end
            chk("R5", {out_empty, out_err, rd_data}, {2'b10, 32'h0});
            rd_en = 1'b1; step(); rd_en = 1'b0;
            chk("R5", {out_err, rd_data}, {1'b1, 32'h0});
            chk("R10", {in_err, out_err}, 2'b11);
        end
        start = 1'b1; step(); start = 1'b0;
        chk("R10", {in_err, out_err, in_empty, out_empty}, 4'b0011);
        finish_run();
    end
endmodule